// File: doc/BRIEF.md
# Round-Robin Device Polling Scheduler

This block is the host-side sequencer for a two-wire serial bus on which devices join at run time. It keeps a small table of device addresses and visits them in a loop with equal weight. Each visit is one slot: a command write to the device, then a response read from it. After the last known device it issues a general call on the broadcast address, so that devices not yet known can announce themselves. New addresses come in on the table update port. The scheduler hands one transaction at a time to a separate bus transaction engine and waits for that engine to report completion before it asks for the next one.

A device that fails its slot on three passes in a row is dropped from the table. When the table is empty, the loop has only the general call, with a programmable pause between calls. The state machine has eight states. SCAN picks the next valid entry at or above the scan pointer. CMD_REQ and CMD_WAIT issue the write and wait for it. RSP_REQ and RSP_WAIT do the same for the read. GC_REQ and GC_WAIT issue the general call. IDLE is the pause.

The transitions are these. SCAN goes to CMD_REQ when it finds an entry and to GC_REQ when it does not. CMD_REQ goes to CMD_WAIT. CMD_WAIT goes to RSP_REQ on a good completion and back to SCAN on a failed one. RSP_REQ goes to RSP_WAIT. RSP_WAIT goes to SCAN on completion. GC_REQ goes to GC_WAIT. On completion, GC_WAIT goes to SCAN with the pointer reset to 0 if any entry is valid, and to IDLE otherwise. IDLE goes to GC_REQ when its timer expires. Reset enters SCAN with the pointer at 0.

Top module: `poll_sched`

## Requirements
- R1: After reset, busy and req_start are 0. With the table empty, the first request is a general call: address 0x00, req_rnw=0, opcode 0xC0.
- R2: While the table is empty, each completed general call is followed by IDLE. The next general call request then appears idle_gap+1 clock edges after the edge that accepted the completion.
- R3: The update port stores a new address in the lowest-numbered free entry. Entries are polled in ascending index order.
- R4: An address already valid in the table is not stored a second time.
- R5: When all 16 entries are valid, further additions are ignored.
- R6: Each slot is a write request (req_rnw=0, opcode 0xC1) followed by a read request (req_rnw=1, opcode 0xC2) to the same address. The read is only issued after the write completes without failure.
- R7: After every pass over the table, exactly one general call is issued. If the table is not empty, the first request of the next pass appears on the second clock edge after the general call completes.
- R8: req_start is a one-cycle pulse. No new request starts while a transaction is outstanding. busy stays 1 from req_start until the completion is accepted.
- R9: If the write of a slot completes with txn_fail=1, the read is skipped and the slot counts as a miss.
- R10: An entry with three consecutive missed slots is invalidated. A fully successful slot clears its miss count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_gap | input | IDLE_W | Pause length between general calls when the table is empty |
| add_valid | input | 1 | Strobe: add add_addr to the table |
| add_addr | input | ADDR_W | Address learned during discovery |
| txn_done | input | 1 | Engine pulse: current transaction finished |
| txn_fail | input | 1 | With txn_done: no acknowledge or Not Ack response |
| req_start | output | 1 | One-cycle request to the engine |
| req_addr | output | ADDR_W | Target address of the request |
| req_rnw | output | 1 | 1 = read, 0 = write |
| req_opcode | output | 8 | Opcode of the request |
| busy | output | 1 | A transaction is requested or outstanding |

## Verification
The bench first runs an empty table with gaps of 5, 0 and 3 cycles. The differing delays separate the IDLE path from the immediate restart taken after a pass over a non-empty table. Three addresses, one of them sent twice, check that the poll order follows the insertion index and that duplicates are rejected. Next, one device keeps failing its write while another fails its read on two passes and then succeeds. This shows that a failed write skips the read, and that removal needs three misses in a row rather than three in total. Finally, the hole left by the removed entry and the remaining free entries are filled with more addresses than fit. This checks lowest-free placement and the full-table limit.

// File: rtl/poll_pkg.sv
package poll_pkg;
    localparam int OPC_W = 8;
    localparam logic [OPC_W-1:0] OPC_GCALL = 8'hC0;
    localparam logic [OPC_W-1:0] OPC_CMD   = 8'hC1;
    localparam logic [OPC_W-1:0] OPC_RSP   = 8'hC2;

    typedef enum logic [2:0] {
        ST_SCAN, ST_CMD_REQ, ST_CMD_WAIT, ST_RSP_REQ,
        ST_RSP_WAIT, ST_GC_REQ, ST_GC_WAIT, ST_IDLE
    } sched_state_e;
endpackage

// File: rtl/poll_table.sv
module poll_table #(
    parameter int DEPTH      = 16,
    parameter int ADDR_W     = 7,
    parameter int MISS_LIMIT = 3,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int PTR_W     = IDX_W + 1,
    localparam int MISS_W    = $clog2(MISS_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_valid,
    input  logic [ADDR_W-1:0] add_addr,
    input  logic              upd_we,
    input  logic [IDX_W-1:0]  upd_idx,
    input  logic              upd_fail,
    input  logic [PTR_W-1:0]  scan_from,
    output logic              found,
    output logic [IDX_W-1:0]  found_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              any_valid
);
    logic              valid_q [DEPTH];
    logic [ADDR_W-1:0] addr_q  [DEPTH];
    logic [MISS_W-1:0] miss_q  [DEPTH];
    logic              free_ok, dup;
    logic [IDX_W-1:0]  free_idx;
    logic              dup_pair;

    always_comb begin
        found     = 1'b0;
        found_idx = '0;
        free_ok   = 1'b0;
        free_idx  = '0;
        dup       = 1'b0;
        any_valid = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && valid_q[i] && (PTR_W'(i) >= scan_from)) begin
                found     = 1'b1;
                found_idx = IDX_W'(i);
            end
            if (!free_ok && !valid_q[i]) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (valid_q[i] && addr_q[i] == add_addr) dup = 1'b1;
            if (valid_q[i]) any_valid = 1'b1;
        end
    end

    assign rd_addr = addr_q[rd_idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                addr_q[g]  <= '0;
                miss_q[g]  <= '0;
            end else if (upd_we && upd_idx == IDX_W'(g) && valid_q[g]) begin
                if (!upd_fail) begin
                    miss_q[g] <= '0;
                end else if (miss_q[g] == MISS_W'(MISS_LIMIT - 1)) begin
                    valid_q[g] <= 1'b0;
                    miss_q[g]  <= '0;
                end else begin
                    miss_q[g] <= miss_q[g] + 1'b1;
                end
            end else if (add_valid && free_ok && !dup && free_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b1;
                addr_q[g]  <= add_addr;
                miss_q[g]  <= '0;
            end
        end

        // R10
        drop_after_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(valid_q[g]) |-> $past(upd_we && upd_fail && upd_idx == IDX_W'(g)));
    end

    always_comb begin
        dup_pair = 1'b0;
        for (int a = 0; a < DEPTH; a++)
            for (int b = a + 1; b < DEPTH; b++)
                if (valid_q[a] && valid_q[b] && addr_q[a] == addr_q[b]) dup_pair = 1'b1;
    end

    // R4
    no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_pair);
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [IDLE_W-1:0] limit,
    output logic              expired
);
    logic [IDLE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q != limit) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == limit);
endmodule

// File: rtl/poll_sched.sv
module poll_sched
    import poll_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int ADDR_W     = 7,
    parameter int MISS_LIMIT = 3,
    parameter int IDLE_W     = 16,
    localparam int IDX_W     = $clog2(DEPTH),
    localparam int PTR_W     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDLE_W-1:0] idle_gap,
    input  logic              add_valid,
    input  logic [ADDR_W-1:0] add_addr,
    input  logic              txn_done,
    input  logic              txn_fail,
    output logic              req_start,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_rnw,
    output logic [OPC_W-1:0]  req_opcode,
    output logic              busy
);
    sched_state_e     state_q, state_d;
    logic [IDX_W-1:0] cur_q, cur_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             found, any_valid, expired;
    logic [IDX_W-1:0] found_idx;
    logic [ADDR_W-1:0] rd_addr;
    logic             upd_we;
    logic             in_gc, in_rsp;

    poll_table #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .MISS_LIMIT(MISS_LIMIT)) u_table (
        .clk(clk), .rst_n(rst_n),
        .add_valid(add_valid), .add_addr(add_addr),
        .upd_we(upd_we), .upd_idx(cur_q), .upd_fail(txn_fail),
        .scan_from(ptr_q), .found(found), .found_idx(found_idx),
        .rd_idx(cur_q), .rd_addr(rd_addr), .any_valid(any_valid)
    );

    idle_timer #(.IDLE_W(IDLE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_IDLE),
        .limit(idle_gap), .expired(expired)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
            cur_q   <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_SCAN: begin
                if (found) begin
                    cur_d   = found_idx;
                    state_d = ST_CMD_REQ;
                end else begin
                    state_d = ST_GC_REQ;
                end
            end
            ST_CMD_REQ:  state_d = ST_CMD_WAIT;
            ST_CMD_WAIT: begin
                if (txn_done && txn_fail) begin
                    ptr_d   = PTR_W'(cur_q) + 1'b1;
                    state_d = ST_SCAN;
                end else if (txn_done) begin
                    state_d = ST_RSP_REQ;
                end
            end
            ST_RSP_REQ:  state_d = ST_RSP_WAIT;
            ST_RSP_WAIT: begin
                if (txn_done) begin
                    ptr_d   = PTR_W'(cur_q) + 1'b1;
                    state_d = ST_SCAN;
                end
            end
            ST_GC_REQ:   state_d = ST_GC_WAIT;
            ST_GC_WAIT: begin
                if (txn_done) begin
                    ptr_d   = '0;
                    state_d = any_valid ? ST_SCAN : ST_IDLE;
                end
            end
            ST_IDLE: if (expired) state_d = ST_GC_REQ;
            default: state_d = ST_SCAN;
        endcase
    end

    always_comb begin
        in_gc      = (state_q == ST_GC_REQ) || (state_q == ST_GC_WAIT);
        in_rsp     = (state_q == ST_RSP_REQ) || (state_q == ST_RSP_WAIT);
        req_start  = (state_q == ST_CMD_REQ) || (state_q == ST_RSP_REQ) || (state_q == ST_GC_REQ);
        busy       = req_start || (state_q == ST_CMD_WAIT) || (state_q == ST_RSP_WAIT)
                     || (state_q == ST_GC_WAIT);
        req_addr   = in_gc ? '0 : rd_addr;
        req_rnw    = in_rsp;
        req_opcode = in_gc ? OPC_GCALL : (in_rsp ? OPC_RSP : OPC_CMD);
        upd_we     = txn_done && (((state_q == ST_CMD_WAIT) && txn_fail) || (state_q == ST_RSP_WAIT));
    end

    logic              pend_q, wr_ok_q;
    logic [ADDR_W-1:0] wr_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            wr_ok_q   <= 1'b0;
            wr_addr_q <= '0;
        end else begin
            if (req_start) pend_q <= 1'b1;
            else if (txn_done) pend_q <= 1'b0;
            if (req_start) wr_ok_q <= 1'b0;
            else if (txn_done && !txn_fail && state_q == ST_CMD_WAIT) wr_ok_q <= 1'b1;
            if (req_start && !req_rnw) wr_addr_q <= req_addr;
        end
    end

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_start |-> !pend_q);

    // R6
    rd_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && req_rnw) |-> (wr_ok_q && req_addr == wr_addr_q));
endmodule

// File: tb/test_poll_sched.sv
module test_poll_sched;
    import poll_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] idle_gap = 16'd5;
    logic        add_valid = 1'b0;
    logic [6:0]  add_addr = '0;
    logic        txn_done = 1'b0;
    logic        txn_fail = 1'b0;
    logic        req_start, req_rnw, busy;
    logic [6:0]  req_addr;
    logic [7:0]  req_opcode;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [6:0] m_addr [16];
    bit         m_valid [16];
    int         m_miss [16];
    bit         bw_en = 0;
    logic [6:0] bw_addr = '0;
    logic [6:0] br_addr = '0;
    int         br_left = 0;

    always #10 clk = ~clk;

    poll_sched i_poll_sched (
        .clk(clk), .rst_n(rst_n), .idle_gap(idle_gap),
        .add_valid(add_valid), .add_addr(add_addr),
        .txn_done(txn_done), .txn_fail(txn_fail),
        .req_start(req_start), .req_addr(req_addr), .req_rnw(req_rnw),
        .req_opcode(req_opcode), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_req();
        for (int n = 0; n < 2000 && !req_start; n++) @(negedge clk);
        if (!req_start) check(1'b0, "R8 request timeout", 0, 1);
    endtask

    task automatic finish_txn(input bit fail);
        @(negedge clk);
        check(!req_start && busy, "R8 single pulse and busy", {req_start, busy}, 1);
        txn_done = 1'b1;
        txn_fail = fail;
        @(negedge clk);
        txn_done = 1'b0;
        txn_fail = 1'b0;
    endtask

    task automatic expect_req(input logic [6:0] a, input bit r, input logic [7:0] o, input string tag);
        wait_req();
        check(req_addr == a, {tag, " addr"}, req_addr, a);
        check(req_rnw == r && req_opcode == o, {tag, " kind"}, {req_rnw, req_opcode}, {r, o});
    endtask

    task automatic measure_gap(input int exp, input string tag);
        int cnt = 1;
        for (int n = 0; n < 2000 && !req_start; n++) begin
            @(negedge clk);
            cnt++;
        end
        check(cnt == exp, tag, cnt, exp);
    endtask

    task automatic add_dev(input logic [6:0] a);
        bit dup = 0;
        int fr = -1;
        add_valid = 1'b1;
        add_addr  = a;
        @(negedge clk);
        add_valid = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (m_valid[i] && m_addr[i] == a) dup = 1;
            if (fr < 0 && !m_valid[i]) fr = i;
        end
        if (!dup && fr >= 0) begin
            m_valid[fr] = 1;
            m_addr[fr]  = a;
            m_miss[fr]  = 0;
        end
    endtask

    task automatic run_slots(input string tag);
        for (int i = 0; i < 16; i++) begin
            if (m_valid[i]) begin
                bit wf, rf;
                wf = bw_en && (m_addr[i] == bw_addr);
                expect_req(m_addr[i], 1'b0, OPC_CMD, {tag, " R3 R6 write"});
                finish_txn(wf);
                if (wf) begin
                    m_miss[i]++;
                end else begin
                    rf = (m_addr[i] == br_addr) && (br_left > 0);
                    if (rf) br_left--;
                    expect_req(m_addr[i], 1'b1, OPC_RSP, {tag, " R6 R9 read"});
                    finish_txn(rf);
                    m_miss[i] = rf ? m_miss[i] + 1 : 0;
                end
                if (m_miss[i] == 3) begin
                    m_valid[i] = 0;
                    m_miss[i]  = 0;
                end
            end
        end
    endtask

    task automatic run_pass(input string tag);
        run_slots(tag);
        expect_req(7'h00, 1'b0, OPC_GCALL, {tag, " R7 general call"});
        finish_txn(1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!busy && !req_start, "R1 reset outputs", {busy, req_start}, 0);
        rst_n = 1'b1;
        expect_req(7'h00, 1'b0, OPC_GCALL, "R1 first request");
    endtask

    task automatic t_empty_idle();
        idle_gap = 16'd5;
        finish_txn(1'b0);
        measure_gap(7, "R2 gap 5");
        expect_req(7'h00, 1'b0, OPC_GCALL, "R2 repeat call");
        idle_gap = 16'd0;
        finish_txn(1'b0);
        measure_gap(2, "R2 gap 0");
        expect_req(7'h00, 1'b0, OPC_GCALL, "R2 repeat call");
        idle_gap = 16'd3;
        finish_txn(1'b0);
        measure_gap(5, "R2 gap 3");
    endtask

    task automatic t_register();
        idle_gap = 16'd5;
        expect_req(7'h00, 1'b0, OPC_GCALL, "R2 call before adds");
        add_dev(7'h21);
        add_dev(7'h15);
        add_dev(7'h33);
        add_dev(7'h15);
        finish_txn(1'b0);
        measure_gap(2, "R7 restart after pass");
        run_pass("pass1");
        measure_gap(2, "R7 restart after pass");
        run_pass("R4 pass2");
    endtask

    task automatic t_failures();
        bw_en   = 1;
        bw_addr = 7'h15;
        br_addr = 7'h33;
        br_left = 2;
        run_pass("R9 fpass1");
        run_pass("R10 fpass2");
        run_pass("R10 fpass3");
        run_pass("R10 fpass4");
        bw_en = 0;
    endtask

    task automatic t_full();
        run_slots("pre-full");
        expect_req(7'h00, 1'b0, OPC_GCALL, "R7 call");
        for (int k = 0; k < 15; k++) add_dev(7'h40 + 7'(k));
        add_dev(7'h21);
        finish_txn(1'b0);
        run_pass("R5 full");
        check(m_addr[1] == 7'h40, "R3 lowest free entry", m_addr[1], 7'h40);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_valid[i] = 0;
            m_addr[i]  = '0;
            m_miss[i]  = 0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        t_empty_idle();
        t_register();
        t_failures();
        t_full();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule